// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the architectural integer registers of a 32-bit processor core whose register set changes with the operating mode. Sixteen register numbers are visible at any time. Number 15 is the program counter, 14 the link register, 13 the stack pointer and 0 to 12 general data. Physical storage is banked. The five exception modes each keep private stack pointer and link register copies. Fast-interrupt mode also keeps private copies of numbers 8 to 12. The same number can therefore reach a different storage word in each mode. User mode, system mode and any unlisted mode code use the shared set.

The file has two combinational read ports and one write port, all decoded through the mode on `mode_i`. The program counter lives outside the file. Reading number 15 returns `pc_i`, and writing number 15 is turned into a branch request. The block also keeps one current status word and one saved status word for each exception mode. A side port copies the current status into the saved status word of a chosen exception mode, for use on exception entry.

Top module: `banked_regfile`

## Requirements
- R1: Mode codes are 0x10 user, 0x11 fast interrupt, 0x12 interrupt, 0x13 supervisor, 0x17 abort, 0x1B undefined and 0x1F system. In user mode, system mode and any other code, numbers 0 to 14 address one shared set of 15 words. Reads are combinational and writes take effect at the clock edge.
- R2: Interrupt, supervisor, abort and undefined modes (0x12, 0x13, 0x17, 0x1B) each address a private copy of numbers 13 and 14. Their numbers 0 to 12 reach the shared set.
- R3: Fast-interrupt mode (0x11) addresses private copies of numbers 8 to 14. Its numbers 0 to 7 reach the shared set.
- R4: A write to a banked number in one mode leaves the copy seen by every other mode unchanged.
- R5: A read of number 15 on either port returns `pc_i` in the same cycle.
- R6: A write to number 15 raises `branch_o` in the same cycle, with `branch_addr_o` equal to the write data, and stores nothing.
- R7: When a read and a write reach the same storage word in one cycle, the read returns the write data.
- R8: `spsr_o` shows the saved status word of the current exception mode. It is zero in user, system and unlisted modes, and a saved status write in those modes is ignored.
- R9: With `save_en_i` high and an exception code on `save_mode_i`, that mode's saved status word takes the value `cpsr_o` held before the edge. This has priority over a saved status write to the same word in that cycle.
- R10: `cpsr_o` resets to 0x000000D3 and takes `cpsr_wdata_i` at the edge after `cpsr_we_i` is high.
- R11: Reset clears every stored register word and every saved status word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Current processor mode code |
| pc_i | input | 32 | Program counter value returned for number 15 |
| ra_idx_i | input | 4 | Read port A register number |
| ra_data_o | output | 32 | Read port A data |
| rb_idx_i | input | 4 | Read port B register number |
| rb_data_o | output | 32 | Read port B data |
| we_i | input | 1 | Register write enable |
| w_idx_i | input | 4 | Write register number |
| w_data_i | input | 32 | Write data |
| branch_o | output | 1 | Write to number 15 seen this cycle |
| branch_addr_o | output | 32 | Target carried by the number-15 write |
| cpsr_we_i | input | 1 | Current status write enable |
| cpsr_wdata_i | input | 32 | Current status write data |
| cpsr_o | output | 32 | Current status word |
| spsr_we_i | input | 1 | Saved status write enable for the current mode |
| spsr_wdata_i | input | 32 | Saved status write data |
| spsr_o | output | 32 | Saved status word of the current mode |
| save_en_i | input | 1 | Copy current status into a saved status word |
| save_mode_i | input | 5 | Mode whose saved status word receives the copy |

## Verification
Read data, `branch_o`, `branch_addr_o` and `spsr_o` follow their inputs in the same cycle. This includes the forwarded value on a read-write collision. Writes to register words, the current status and the saved status words show up only after the next rising edge. The bench drives every input at the falling edge and compares all outputs one nanosecond later against a behavioural model. It then advances the model at the rising edge, so each write is first checked one cycle after it is issued. Directed sequences cover cross-mode isolation, save priority and status writes in modes without a saved word. A long random run follows.

// File: rtl/bank_rf_pkg.sv
package bank_rf_pkg;
  typedef enum logic [4:0] {
    M_USR = 5'h10, M_FIQ = 5'h11, M_IRQ = 5'h12, M_SVC = 5'h13,
    M_ABT = 5'h17, M_UND = 5'h1B, M_SYS = 5'h1F
  } mode_e;

  localparam int NUM_ARCH   = 16;
  localparam int NUM_SHARED = NUM_ARCH - 1;
  localparam int FIQ_LO     = 8;
  localparam int EXC_LO     = 13;
  localparam int FIQ_BANK   = NUM_SHARED - FIQ_LO;
  localparam int EXC_BANK   = NUM_SHARED - EXC_LO;
  localparam int NUM_SPSR   = 5;
  localparam int NUM_PHYS   = NUM_SHARED + FIQ_BANK + (NUM_SPSR - 1) * EXC_BANK;
  localparam int PHYS_W     = $clog2(NUM_PHYS);
  localparam int SLOT_W     = $clog2(NUM_SPSR);

  function automatic logic has_spsr(logic [4:0] m);
    case (m)
      M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND: has_spsr = 1'b1;
      default:                          has_spsr = 1'b0;
    endcase
  endfunction

  // slot 0 is fast interrupt; it is also the seven-word bank
  function automatic logic [SLOT_W-1:0] spsr_slot(logic [4:0] m);
    case (m)
      M_IRQ:   spsr_slot = SLOT_W'(1);
      M_SVC:   spsr_slot = SLOT_W'(2);
      M_ABT:   spsr_slot = SLOT_W'(3);
      M_UND:   spsr_slot = SLOT_W'(4);
      default: spsr_slot = SLOT_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/bank_map.sv
module bank_map
  import bank_rf_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [4:0]       mode_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [PHYS_W-1:0] phys_o,
  output logic             pc_o
);
  always_comb begin
    pc_o   = (idx_i == IDX_W'(NUM_ARCH - 1));
    phys_o = PHYS_W'(idx_i);
    if (has_spsr(mode_i) && !pc_o) begin
      if (spsr_slot(mode_i) == '0) begin
        if (idx_i >= IDX_W'(FIQ_LO))
          phys_o = PHYS_W'(NUM_SHARED + int'(idx_i) - FIQ_LO);
      end else if (idx_i >= IDX_W'(EXC_LO)) begin
        phys_o = PHYS_W'(NUM_SHARED + FIQ_BANK
                         + (int'(spsr_slot(mode_i)) - 1) * EXC_BANK
                         + int'(idx_i) - EXC_LO);
      end
    end
  end
endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
  parameter int DATA_W = 32,
  parameter int N_WORDS = 30,
  parameter int N_RD = 2,
  localparam int AW = $clog2(N_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i [N_RD],
  output logic [DATA_W-1:0] rdata_o [N_RD]
);
  logic [DATA_W-1:0] mem [N_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_WORDS; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    // write-through on same-word collision
    assign rdata_o[p] = (we_i && waddr_i == raddr_i[p]) ? wdata_i : mem[raddr_i[p]];
  end
endmodule

// File: rtl/psr_store.sv
module psr_store
  import bank_rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] CPSR_RST = DATA_W'(32'h0000_00D3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        mode_i,
  input  logic              cpsr_we_i,
  input  logic [DATA_W-1:0] cpsr_wdata_i,
  input  logic              spsr_we_i,
  input  logic [DATA_W-1:0] spsr_wdata_i,
  input  logic              save_en_i,
  input  logic [4:0]        save_mode_i,
  output logic [DATA_W-1:0] cpsr_o,
  output logic [DATA_W-1:0] spsr_o
);
  logic [DATA_W-1:0] cpsr_q;
  logic [DATA_W-1:0] spsr_vec [NUM_SPSR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cpsr_q <= CPSR_RST;
    else if (cpsr_we_i) cpsr_q <= cpsr_wdata_i;
  end

  for (genvar s = 0; s < NUM_SPSR; s++) begin : g_spsr
    logic [DATA_W-1:0] q;
    logic save_hit, wr_hit;
    assign save_hit = save_en_i && has_spsr(save_mode_i) && spsr_slot(save_mode_i) == SLOT_W'(s);
    assign wr_hit   = spsr_we_i && has_spsr(mode_i) && spsr_slot(mode_i) == SLOT_W'(s);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= '0;
      else if (save_hit) q <= cpsr_q;
      else if (wr_hit)   q <= spsr_wdata_i;
    end
    assign spsr_vec[s] = q;
  end

  assign cpsr_o = cpsr_q;
  assign spsr_o = has_spsr(mode_i) ? spsr_vec[spsr_slot(mode_i)] : '0;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bank_rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        mode_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic [IDX_W-1:0]  ra_idx_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [IDX_W-1:0]  rb_idx_i,
  output logic [DATA_W-1:0] rb_data_o,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  w_idx_i,
  input  logic [DATA_W-1:0] w_data_i,
  output logic              branch_o,
  output logic [DATA_W-1:0] branch_addr_o,
  input  logic              cpsr_we_i,
  input  logic [DATA_W-1:0] cpsr_wdata_i,
  output logic [DATA_W-1:0] cpsr_o,
  input  logic              spsr_we_i,
  input  logic [DATA_W-1:0] spsr_wdata_i,
  output logic [DATA_W-1:0] spsr_o,
  input  logic              save_en_i,
  input  logic [4:0]        save_mode_i
);
  localparam int N_PORTS = 3;  // two reads, one write

  logic [IDX_W-1:0]  idx   [N_PORTS];
  logic [PHYS_W-1:0] phys  [N_PORTS];
  logic              is_pc [N_PORTS];
  logic [PHYS_W-1:0] raddr [2];
  logic [DATA_W-1:0] rdata [2];

  assign idx[0] = ra_idx_i;
  assign idx[1] = rb_idx_i;
  assign idx[2] = w_idx_i;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_map
    bank_map #(.IDX_W(IDX_W)) u_map (
      .mode_i (mode_i),
      .idx_i  (idx[p]),
      .phys_o (phys[p]),
      .pc_o   (is_pc[p])
    );
  end

  assign raddr[0] = phys[0];
  assign raddr[1] = phys[1];

  gpr_store #(.DATA_W(DATA_W), .N_WORDS(NUM_PHYS), .N_RD(2)) u_gpr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i && !is_pc[2]),
    .waddr_i (phys[2]),
    .wdata_i (w_data_i),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  assign ra_data_o     = is_pc[0] ? pc_i : rdata[0];
  assign rb_data_o     = is_pc[1] ? pc_i : rdata[1];
  assign branch_o      = we_i && is_pc[2];
  assign branch_addr_o = w_data_i;

  psr_store #(.DATA_W(DATA_W)) u_psr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode_i),
    .cpsr_we_i    (cpsr_we_i),
    .cpsr_wdata_i (cpsr_wdata_i),
    .spsr_we_i    (spsr_we_i),
    .spsr_wdata_i (spsr_wdata_i),
    .save_en_i    (save_en_i),
    .save_mode_i  (save_mode_i),
    .cpsr_o       (cpsr_o),
    .spsr_o       (spsr_o)
  );
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
  import bank_rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [4:0]        mode_i,
  input logic [DATA_W-1:0] pc_i,
  input logic [IDX_W-1:0]  ra_idx_i,
  input logic [DATA_W-1:0] ra_data_o,
  input logic [IDX_W-1:0]  rb_idx_i,
  input logic [DATA_W-1:0] rb_data_o,
  input logic              we_i,
  input logic [IDX_W-1:0]  w_idx_i,
  input logic [DATA_W-1:0] w_data_i,
  input logic              branch_o,
  input logic [DATA_W-1:0] branch_addr_o,
  input logic              cpsr_we_i,
  input logic [DATA_W-1:0] cpsr_wdata_i,
  input logic [DATA_W-1:0] cpsr_o,
  input logic              spsr_we_i,
  input logic [DATA_W-1:0] spsr_wdata_i,
  input logic [DATA_W-1:0] spsr_o,
  input logic              save_en_i,
  input logic [4:0]        save_mode_i
);
  localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(NUM_ARCH - 1);

  a_r5_pc_read_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ra_idx_i == PC_IDX |-> ra_data_o == pc_i);

  a_r5_pc_read_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_idx_i == PC_IDX |-> rb_data_o == pc_i);

  a_r6_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && w_idx_i == PC_IDX) |-> (branch_o && branch_addr_o == w_data_i));

  a_r6_no_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && w_idx_i == PC_IDX) |-> !branch_o);

  a_r7_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && w_idx_i != PC_IDX && w_idx_i == ra_idx_i) |-> ra_data_o == w_data_i);

  a_r8_spsr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !has_spsr(mode_i) |-> spsr_o == '0);

  a_r10_cpsr_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpsr_we_i |=> cpsr_o == $past(cpsr_wdata_i));

  a_r9_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_en_i && has_spsr(save_mode_i)) ##1 (mode_i == $past(save_mode_i))
      |-> spsr_o == $past(cpsr_o));
endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mode = 5'h10;
  logic [31:0] pc = '0;
  logic [3:0]  ra_idx = '0, rb_idx = '0, w_idx = '0;
  logic [31:0] ra_data, rb_data, w_data = '0;
  logic        we = 1'b0, branch;
  logic [31:0] branch_addr;
  logic        cpsr_we = 1'b0, spsr_we = 1'b0, save_en = 1'b0;
  logic [31:0] cpsr_wdata = '0, spsr_wdata = '0, cpsr, spsr;
  logic [4:0]  save_mode = 5'h10;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  string tag_force = "";

  logic [31:0] gm [int];
  logic [31:0] sm [int];
  logic [31:0] cpsr_m;

  always #2.5 clk = ~clk;

  banked_regfile u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .pc_i(pc),
    .ra_idx_i(ra_idx), .ra_data_o(ra_data), .rb_idx_i(rb_idx), .rb_data_o(rb_data),
    .we_i(we), .w_idx_i(w_idx), .w_data_i(w_data),
    .branch_o(branch), .branch_addr_o(branch_addr),
    .cpsr_we_i(cpsr_we), .cpsr_wdata_i(cpsr_wdata), .cpsr_o(cpsr),
    .spsr_we_i(spsr_we), .spsr_wdata_i(spsr_wdata), .spsr_o(spsr),
    .save_en_i(save_en), .save_mode_i(save_mode)
  );

  function automatic bit is_exc2(logic [4:0] m);
    return m == 5'h12 || m == 5'h13 || m == 5'h17 || m == 5'h1B;
  endfunction
  function automatic bit has_saved(logic [4:0] m);
    return is_exc2(m) || m == 5'h11;
  endfunction
  function automatic int key(logic [4:0] m, int i);
    if (m == 5'h11 && i >= 8) return 1000 + i;
    if (is_exc2(m) && i >= 13) return int'(m) * 16 + i;
    return i;
  endfunction
  function automatic logic [31:0] gval(int k);
    return gm.exists(k) ? gm[k] : 32'h0;
  endfunction

  function automatic string rd_tag(int i);
    if (tag_force != "") return tag_force;
    if (i == 15) return "R5";
    if (we && w_idx != 4'd15 && key(mode, int'(w_idx)) == key(mode, i)) return "R7";
    if (mode == 5'h11 && i >= 8) return "R3";
    if (is_exc2(mode) && i >= 13) return "R2";
    return "R1";
  endfunction
  function automatic logic [31:0] exp_rd(int i);
    if (i == 15) return pc;
    if (we && w_idx != 4'd15 && key(mode, int'(w_idx)) == key(mode, i)) return w_data;
    return gval(key(mode, i));
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // inputs already set after a falling edge
  task automatic step();
    logic [31:0] old_cpsr;
    bit exp_br;
    #1;
    exp_br = we && w_idx == 4'd15;
    chk(rd_tag(int'(ra_idx)), "ra_data", ra_data, exp_rd(int'(ra_idx)));
    chk(rd_tag(int'(rb_idx)), "rb_data", rb_data, exp_rd(int'(rb_idx)));
    chk(tag_force != "" ? tag_force : "R6", "branch", {31'b0, branch}, {31'b0, exp_br});
    if (exp_br) chk("R6", "branch_addr", branch_addr, w_data);
    chk(tag_force != "" ? tag_force : "R10", "cpsr", cpsr, cpsr_m);
    chk(tag_force != "" ? tag_force : "R8", "spsr", spsr,
        (has_saved(mode) && sm.exists(int'(mode))) ? sm[int'(mode)] : 32'h0);
    @(posedge clk);
    old_cpsr = cpsr_m;
    if (we && w_idx != 4'd15) gm[key(mode, int'(w_idx))] = w_data;
    if (cpsr_we) cpsr_m = cpsr_wdata;
    if (spsr_we && has_saved(mode)) sm[int'(mode)] = spsr_wdata;
    if (save_en && has_saved(save_mode)) sm[int'(save_mode)] = old_cpsr;
    @(negedge clk);
  endtask

  task automatic idle();
    we = 0; cpsr_we = 0; spsr_we = 0; save_en = 0;
  endtask

  task automatic wr(logic [4:0] m, int i, logic [31:0] d);
    idle(); mode = m; we = 1; w_idx = 4'(i); w_data = d; step();
  endtask

  task automatic rd(logic [4:0] m, int a, int b);
    idle(); mode = m; ra_idx = 4'(a); rb_idx = 4'(b); step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [4:0] modes [8];
    modes = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h00};
    cpsr_m = 32'h0000_00D3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 / R10: reset state
    tag_force = "R11";
    for (int i = 0; i < 15; i++) rd(5'h10, i, 14 - i);
    rd(5'h11, 8, 14); rd(5'h12, 13, 14); rd(5'h1B, 13, 14);
    tag_force = "";

    // R4: cross-mode isolation of banked numbers
    wr(5'h10, 13, 32'hAAAA_0013);
    wr(5'h12, 13, 32'h1111_0013);
    wr(5'h11, 13, 32'h2222_0013);
    wr(5'h11, 9, 32'h2222_0009);
    wr(5'h13, 14, 32'h3333_0014);
    tag_force = "R4";
    rd(5'h10, 13, 9); rd(5'h1F, 14, 9); rd(5'h12, 13, 14);
    rd(5'h13, 13, 14); rd(5'h11, 13, 9); rd(5'h17, 13, 14);
    tag_force = "";

    // R5 / R6: program counter read and branch
    pc = 32'h0000_8000; rd(5'h10, 15, 15);
    wr(5'h13, 15, 32'h0000_1234);
    rd(5'h13, 14, 15);

    // R7: write-through on collision in banked and shared words
    idle(); mode = 5'h11; we = 1; w_idx = 4'd10; w_data = 32'hBEEF_000A;
    ra_idx = 4'd10; rb_idx = 4'd2; step();

    // R9: save priority over a saved status write to the same word
    idle(); cpsr_we = 1; cpsr_wdata = 32'h6000_0010; step();
    tag_force = "R9";
    idle(); mode = 5'h12; spsr_we = 1; spsr_wdata = 32'hDEAD_0000;
    save_en = 1; save_mode = 5'h12; step();
    rd(5'h12, 0, 1);
    tag_force = "";

    // R8: saved status writes ignored without an exception mode
    tag_force = "R8";
    idle(); mode = 5'h10; spsr_we = 1; spsr_wdata = 32'hFFFF_FFFF; step();
    idle(); mode = 5'h1F; spsr_we = 1; spsr_wdata = 32'hFFFF_FFFF; step();
    rd(5'h10, 0, 0); rd(5'h12, 0, 0); rd(5'h11, 0, 0);
    tag_force = "";

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      mode = modes[$urandom_range(0, 7)];
      pc = $urandom;
      ra_idx = 4'($urandom_range(0, 15));
      rb_idx = ($urandom_range(0, 3) == 0) ? ra_idx : 4'($urandom_range(0, 15));
      we = $urandom_range(0, 1) == 1;
      w_idx = ($urandom_range(0, 3) == 0) ? ra_idx : 4'($urandom_range(0, 15));
      w_data = $urandom;
      cpsr_we = $urandom_range(0, 9) == 0; cpsr_wdata = $urandom;
      spsr_we = $urandom_range(0, 6) == 0; spsr_wdata = $urandom;
      save_en = $urandom_range(0, 6) == 0;
      save_mode = ($urandom_range(0, 1) == 0) ? mode : modes[$urandom_range(0, 7)];
      step();
    end
    idle();
    finish_run();
  end
endmodule